// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs read and write cycles on an external bus whose address and data share one set of pins. Each cycle is built from half-clock phases. An address strobe goes high and the address is placed on the shared pins. The strobe then falls so that an external latch can capture the address. After that a read strobe, or one or both byte write strobes, go low for a programmable number of clocks. Per-region options lengthen the address setup and the address hold. An external wait input can stretch the strobe further. An optional idle state separates a read from the next address phase.

The sequencer runs on a phase clock at twice the CPU clock rate, so one tick is half a CPU clock. On the CPU side there is a one-entry request slot. The CPU pulses `req` while `busy` is low. When the cycle ends, the block pulses `ready` for one tick, and for a read the captured data is on `rdata`. A bus-hold request is granted only between cycles. While the hold is granted, every bus output floats, and any queued CPU request waits until the hold is released.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: After reset: `astb`=0, `rd_n`=1, every `wr_n` bit =1, `ad_oe`=0, `ctl_oe`=1, `hold_ack`=0, `ready`=0, `busy`=0.
- R2: At the start of a cycle `astb` is high for 2 ticks, or 4 ticks when `asw_en[r]` is set. Region r is the most significant bit of the address. The address is on `ad_o` with `ad_oe`=1 during the last tick before `astb` falls.
- R3: The strobe falls 1 tick after `astb` falls, or 3 ticks after when `ahw_en[r]` is set.
- R4: With no external wait, a read or write strobe stays low for 2+2n ticks, where n = `wait_clks` (0 to 3).
- R5: `ext_wait` is sampled only at strobe tick 2n (ticks counted from 0 at the strobe fall) and then every second tick. Each high sample adds 2 ticks to the strobe. High levels on other ticks have no effect.
- R6: During a read strobe `ad_oe`=0. `rdata` takes the `ad_i` value present on the last strobe tick, which is the edge at which `rd_n` rises. `ready` is high for exactly the one tick after the strobe rises.
- R7: During a write strobe `ad_o` carries the write data. It stays driven for 2 ticks after the strobe rises. `wr_n[k]` goes low only when byte enable `be[k]`=1.
- R8: When another request is queued, the next address appears 2+2i ticks after `rd_n` rises, where i = `idle_en`.
- R9: `hold_ack` rises only between cycles. While it is high, `astb`=0, no strobe is low, `ad_oe`=0 and `ctl_oe`=0.
- R10: A request accepted during a hold does not start until `hold_req` falls. One tick after the fall, `hold_ack`=0 and `ctl_oe`=1, and the cycle then runs.
- R11: A `req` pulse taken while `busy`=0 makes `busy` high from the next tick until its cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the CPU clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-tick request pulse, valid when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | DATA_W | Address; top bit selects region |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables for writes |
| busy | output | 1 | Request slot occupied |
| ready | output | 1 | One-tick cycle completion |
| rdata | output | DATA_W | Read data |
| wait_clks | input | WAIT_W | Programmable wait clocks n |
| idle_en | input | 1 | Insert one idle clock after reads |
| asw_en | input | 2**REG_W | Address setup wait enable per region |
| ahw_en | input | 2**REG_W | Address hold wait enable per region |
| ad_o | output | DATA_W | Shared address/data pins, out |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | DATA_W | Shared address/data pins, in |
| astb | output | 1 | Address strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | BE_W | Active-low byte write strobes |
| ext_wait | input | 1 | External wait, active high |
| ctl_oe | output | 1 | Drive enable for strobes; 0 while held |
| hold_req | input | 1 | Bus-hold request |
| hold_ack | output | 1 | Bus-hold acknowledge |

## Verification
The bench holds `ext_wait` high from the first strobe tick. A design that sampled it before tick 2n would stretch the strobe by the wrong amount, and the measured strobe length would not match. The read data pins carry a dummy value on every tick except the last strobe tick, so capturing one tick early or late returns the dummy value. The bench raises `hold_req` in the middle of a write strobe, which catches a design that grants a hold mid-cycle. It also queues a request during a hold, which catches a design that starts a cycle while its outputs float. Back-to-back reads with and without the idle state measure the gap from the read strobe rise to the next address, which exposes a miscounted idle phase.

// File: rtl/xbm_pkg.sv
// Shared types for the multiplexed bus controller.
// Assumes one phase tick equals half a CPU clock.
package xbm_pkg;

    // Half-clock phases of a bus cycle plus the two between-cycle states
    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,  // bus quiet, outputs driven
        PH_HOLD = 4'd1,  // bus granted away, outputs float
        PH_STB  = 4'd2,  // strobe high, pins floating
        PH_ADR  = 4'd3,  // strobe high, address driven (+setup wait)
        PH_AHD  = 4'd4,  // strobe low, address held (+hold wait)
        PH_STR  = 4'd5,  // read/write strobe low
        PH_REC  = 4'd6,  // strobe released, completion reported
        PH_TAIL = 4'd7,  // write data hold second half
        PH_RIDL = 4'd8   // idle clock after a read
    } phase_e;

endpackage

// File: rtl/xbm_req_slot.sv
// One-entry request slot between CPU and bus sequencer.
// Loads a request pulse when empty; empties when the sequencer
// starts the cycle. Assumes the CPU only pulses req when valid_o is low.
module xbm_req_slot #(
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              take_i,
    output logic              valid_o,
    output logic              we_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [BE_W-1:0]   be_o
);

    logic load;
    assign load = req_i && !valid_o;

    // Occupancy flag: set on load, cleared when the cycle starts
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_o <= 1'b0;
        else if (take_i) valid_o <= 1'b0;
        else if (load)   valid_o <= 1'b1;
    end

    // Request fields captured on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            be_o    <= '0;
        end else if (load) begin
            we_o    <= we_i;
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
            be_o    <= be_i;
        end
    end

endmodule

// File: rtl/xbm_seq.sv
// Phase sequencer: walks the half-clock phases of one bus cycle and
// decides between cycles whether to grant a hold or start a queued one.
// One shared down-counter times the setup, hold, strobe and idle phases.
// Assumes config inputs are stable for the duration of a cycle.
module xbm_seq
    import xbm_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_v,
    input  logic              hold_req,
    input  logic              ext_wait,
    input  logic [WAIT_W-1:0] wait_clks,
    input  logic              idle_en,
    input  logic              cyc_we,
    input  logic              asw_sel,
    input  logic              ahw_sel,
    output phase_e            phase_o,
    output logic              take_o,
    output logic              cap_o
);

    localparam int CNT_W = WAIT_W + 1;   // holds 2n+1 and the extension value 2

    phase_e            ph, ph_nx, gap_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Between-cycle choice: hold wins over a queued request
    always_comb begin
        if (hold_req)    gap_nx = PH_HOLD;
        else if (pend_v) gap_nx = PH_STB;
        else             gap_nx = PH_IDLE;
    end

    // Next phase and counter load
    always_comb begin
        ph_nx  = ph;
        cnt_nx = cnt;
        case (ph)
            PH_IDLE: ph_nx = gap_nx;
            PH_HOLD: if (!hold_req) ph_nx = PH_IDLE;
            PH_STB: begin
                ph_nx  = PH_ADR;
                cnt_nx = asw_sel ? CNT_W'(2) : '0;
            end
            PH_ADR: begin
                if (cnt_zero) begin
                    ph_nx  = PH_AHD;
                    cnt_nx = ahw_sel ? CNT_W'(2) : '0;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            PH_AHD: begin
                if (cnt_zero) begin
                    ph_nx  = PH_STR;
                    cnt_nx = {wait_clks, 1'b1};
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            PH_STR: begin
                if (cnt_zero)                             ph_nx  = PH_REC;
                else if (cnt == CNT_W'(1) && ext_wait)    cnt_nx = CNT_W'(2);
                else                                      cnt_nx = cnt - 1'b1;
            end
            PH_REC: begin
                if (cyc_we) begin
                    ph_nx = PH_TAIL;
                end else if (idle_en) begin
                    ph_nx  = PH_RIDL;
                    cnt_nx = CNT_W'(1);
                end else begin
                    ph_nx = gap_nx;
                end
            end
            PH_TAIL: ph_nx = gap_nx;
            PH_RIDL: begin
                if (cnt_zero) ph_nx  = gap_nx;
                else          cnt_nx = cnt - 1'b1;
            end
            default: ph_nx = PH_IDLE;
        endcase
    end

    // Phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            ph  <= ph_nx;
            cnt <= cnt_nx;
        end
    end

    assign phase_o = ph;
    assign take_o  = (ph_nx == PH_STB);
    assign cap_o   = (ph == PH_STR) && cnt_zero;

endmodule

// File: rtl/xbm_pin_drv.sv
// Pin driver: holds the active cycle's fields, decodes the phase into
// pin levels and enables, captures read data on the final strobe tick.
// Assumes the region is the top REG_W bits of the address.
module xbm_pin_drv
    import xbm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int REG_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase,
    input  logic                take,
    input  logic                cap,
    input  logic                slot_we,
    input  logic [DATA_W-1:0]   slot_addr,
    input  logic [DATA_W-1:0]   slot_wdata,
    input  logic [BE_W-1:0]     slot_be,
    input  logic [DATA_W-1:0]   ad_i,
    input  logic [2**REG_W-1:0] asw_en,
    input  logic [2**REG_W-1:0] ahw_en,
    output logic                cyc_we,
    output logic                asw_sel,
    output logic                ahw_sel,
    output logic                astb,
    output logic                rd_n,
    output logic [BE_W-1:0]     wr_n,
    output logic [DATA_W-1:0]   ad_o,
    output logic                ad_oe,
    output logic                ctl_oe,
    output logic                hold_ack,
    output logic                ready,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] cur_addr, cur_wdata;
    logic [BE_W-1:0]   cur_be;
    logic [REG_W-1:0]  region;
    logic              strobe_ph, addr_ph, wdat_ph;

    // Active-cycle fields latched as the cycle starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_we    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
        end else if (take) begin
            cyc_we    <= slot_we;
            cur_addr  <= slot_addr;
            cur_wdata <= slot_wdata;
            cur_be    <= slot_be;
        end
    end

    // Read data captured as the read strobe rises
    always_ff @(posedge clk) begin
        if (!rst_n)              rdata <= '0;
        else if (cap && !cyc_we) rdata <= ad_i;
    end

    assign region  = cur_addr[DATA_W-1 -: REG_W];
    assign asw_sel = asw_en[region];
    assign ahw_sel = ahw_en[region];

    assign strobe_ph = (phase == PH_STR);
    assign addr_ph   = (phase == PH_ADR) || (phase == PH_AHD);
    assign wdat_ph   = cyc_we && ((phase == PH_STR) || (phase == PH_REC) || (phase == PH_TAIL));

    assign astb     = (phase == PH_STB) || (phase == PH_ADR);
    assign rd_n     = !(strobe_ph && !cyc_we);
    assign ad_oe    = addr_ph || wdat_ph;
    assign ad_o     = addr_ph ? cur_addr : (wdat_ph ? cur_wdata : '0);
    assign ctl_oe   = (phase != PH_HOLD);
    assign hold_ack = (phase == PH_HOLD);
    assign ready    = (phase == PH_REC);

    // One write strobe per byte lane
    for (genvar k = 0; k < BE_W; k++) begin : g_lane
        assign wr_n[k] = !(strobe_ph && cyc_we && cur_be[k]);
    end

endmodule

// File: rtl/xbus_mux_ctrl.sv
// Multiplexed address/data external bus controller, top level.
// Connects the request slot, phase sequencer and pin driver.
// Assumes clk runs at twice the CPU clock; reset is synchronous active-low.
module xbus_mux_ctrl
    import xbm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int WAIT_W = 2,
    parameter int REG_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_we,
    input  logic [DATA_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]     req_be,
    output logic                busy,
    output logic                ready,
    output logic [DATA_W-1:0]   rdata,
    input  logic [WAIT_W-1:0]   wait_clks,
    input  logic                idle_en,
    input  logic [2**REG_W-1:0] asw_en,
    input  logic [2**REG_W-1:0] ahw_en,
    output logic [DATA_W-1:0]   ad_o,
    output logic                ad_oe,
    input  logic [DATA_W-1:0]   ad_i,
    output logic                astb,
    output logic                rd_n,
    output logic [BE_W-1:0]     wr_n,
    input  logic                ext_wait,
    output logic                ctl_oe,
    input  logic                hold_req,
    output logic                hold_ack
);

    logic              pend_v, slot_we, take, cap, cyc_we, asw_sel, ahw_sel;
    logic [DATA_W-1:0] slot_addr, slot_wdata;
    logic [BE_W-1:0]   slot_be;
    phase_e            phase;

    xbm_req_slot #(.DATA_W(DATA_W), .BE_W(BE_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .we_i    (req_we),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .be_i    (req_be),
        .take_i  (take),
        .valid_o (pend_v),
        .we_o    (slot_we),
        .addr_o  (slot_addr),
        .wdata_o (slot_wdata),
        .be_o    (slot_be)
    );

    xbm_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_v    (pend_v),
        .hold_req  (hold_req),
        .ext_wait  (ext_wait),
        .wait_clks (wait_clks),
        .idle_en   (idle_en),
        .cyc_we    (cyc_we),
        .asw_sel   (asw_sel),
        .ahw_sel   (ahw_sel),
        .phase_o   (phase),
        .take_o    (take),
        .cap_o     (cap)
    );

    xbm_pin_drv #(.DATA_W(DATA_W), .BE_W(BE_W), .REG_W(REG_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .take       (take),
        .cap        (cap),
        .slot_we    (slot_we),
        .slot_addr  (slot_addr),
        .slot_wdata (slot_wdata),
        .slot_be    (slot_be),
        .ad_i       (ad_i),
        .asw_en     (asw_en),
        .ahw_en     (ahw_en),
        .cyc_we     (cyc_we),
        .asw_sel    (asw_sel),
        .ahw_sel    (ahw_sel),
        .astb       (astb),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .ctl_oe     (ctl_oe),
        .hold_ack   (hold_ack),
        .ready      (ready),
        .rdata      (rdata)
    );

    assign busy = pend_v;

endmodule

// File: rtl/xbus_mux_ctrl_chk.sv
// Protocol checker for xbus_mux_ctrl, attached by bind below.
// Observes top-level ports only.
module xbus_mux_ctrl_chk #(
    parameter int BE_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            busy,
    input logic            ready,
    input logic            ad_oe,
    input logic            astb,
    input logic            rd_n,
    input logic [BE_W-1:0] wr_n,
    input logic            ctl_oe,
    input logic            hold_req,
    input logic            hold_ack
);

    logic any_strobe;
    assign any_strobe = !rd_n || (wr_n != {BE_W{1'b1}});

    // R9: no strobe or address activity while the bus is granted away
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !astb && !any_strobe);

    // R9: all outputs float during a hold
    p_float_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !ctl_oe && !ad_oe);

    // R6: shared pins released during a read strobe
    p_rd_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R7: read and write strobes never overlap
    p_rdwr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && (wr_n != {BE_W{1'b1}})));

    // R6: completion follows a strobe that just ended
    p_ready_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !any_strobe && $past(any_strobe));

    // R3: address strobe already low when the read strobe falls
    p_astb_before_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !astb && $past(!astb));

    // R10: acknowledge drops one tick after the request is withdrawn
    p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack && !hold_req |=> !hold_ack);

    // R11: an accepted request occupies the slot
    p_busy_on_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req && !busy |=> busy);

endmodule

bind xbus_mux_ctrl xbus_mux_ctrl_chk #(.BE_W(BE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .ready    (ready),
    .ad_oe    (ad_oe),
    .astb     (astb),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ctl_oe   (ctl_oe),
    .hold_req (hold_req),
    .hold_ack (hold_ack)
);

// File: tb/xbus_mux_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected cycles, a bus monitor
// measures every phase at the pins and compares on each ready pulse.
module xbus_mux_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        busy, ready;
    logic [15:0] rdata;
    logic [1:0]  wait_clks = '0;
    logic        idle_en = 1'b0;
    logic [1:0]  asw_en = '0, ahw_en = '0;
    logic [15:0] ad_o, ad_i;
    logic        ad_oe, astb, rd_n, ctl_oe, hold_ack;
    logic [1:0]  wr_n;
    logic        ext_wait;
    logic        hold_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_mux_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .busy(busy), .ready(ready),
        .rdata(rdata), .wait_clks(wait_clks), .idle_en(idle_en), .asw_en(asw_en),
        .ahw_en(ahw_en), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .astb(astb),
        .rd_n(rd_n), .wr_n(wr_n), .ext_wait(ext_wait), .ctl_oe(ctl_oe),
        .hold_req(hold_req), .hold_ack(hold_ack)
    );

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
        int          exp_astb;
        int          exp_gap;
        int          exp_len;
        int          nwait;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0, n_err = 0;

    function automatic logic [15:0] mem_model(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Driver: wait for a free slot, pulse the request, queue the expectation
    task automatic issue(input logic we, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be, input int nw);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        it.we = we; it.addr = a; it.wdata = d; it.be = be; it.nwait = nw;
        it.exp_astb = 2 + (asw_en[a[15]] ? 2 : 0);
        it.exp_gap  = 1 + (ahw_en[a[15]] ? 2 : 0);
        it.exp_len  = 2 + 2 * int'(wait_clks) + 2 * nw;
        sb_q.push_back(it);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (sb_q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk_eq("drain: all queued cycles completed", sb_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor state
    logic        prev_astb = 1'b0, prev_sl = 1'b0, gap_on = 1'b0;
    logic        rg_on = 1'b0, wh_on = 1'b0, data_ok = 1'b1, rd_float_ok = 1'b1;
    logic        last_we = 1'b0;
    logic [15:0] addr_seen = '0, hold_wd = '0;
    logic [1:0]  wr_seen = '0;
    int          astb_len = 0, meas_astb = 0, gap = 0, meas_gap = 0;
    int          str_len = 0, meas_len = 0, used = 0;
    int          rgap = 0, last_rgap = -1, whold = 0, last_whold = -1;
    int          astb_rises = 0;

    initial begin
        ext_wait = 1'b0;
        ad_i     = 16'hBEEF;
    end

    // Monitor: bus-side model and scoreboard compare, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            logic  sl;
            item_t cur;
            int    j;
            sl = !rd_n || (wr_n != 2'b11);
            if (sb_q.size() > 0) cur = sb_q[0];
            else begin
                cur.we = 1'b0; cur.addr = '0; cur.wdata = '0; cur.be = '0;
                cur.exp_astb = 0; cur.exp_gap = 0; cur.exp_len = 0; cur.nwait = 0;
            end

            if (hold_ack)
                chk_eq("R9 bus quiet and floating while held",
                       (astb || sl || ad_oe || ctl_oe) ? 1 : 0, 0);

            if (astb && !prev_astb) astb_rises++;
            if (astb) begin
                astb_len++;
                if (ad_oe) addr_seen = ad_o;
            end
            if (prev_astb && !astb) begin
                meas_astb = astb_len; astb_len = 0; gap = 1; gap_on = 1'b1;
            end else if (gap_on && !astb && !sl) begin
                gap++;
            end

            if (sl && !prev_sl) begin
                meas_gap = gap; gap_on = 1'b0; str_len = 0; used = 0;
                wr_seen = '0; data_ok = 1'b1; rd_float_ok = 1'b1; last_we = cur.we;
            end

            if (sl) begin
                j = str_len;
                str_len++;
                ext_wait = (used < cur.nwait);
                if (j >= 2 * int'(wait_clks) && ((j - 2 * int'(wait_clks)) % 2 == 0)
                    && used < cur.nwait) used++;
                ad_i = (!cur.we && j == cur.exp_len - 1) ? mem_model(cur.addr) : 16'hDEAD;
                wr_seen = wr_seen | ~wr_n;
                if (cur.we && !(ad_oe && ad_o == cur.wdata)) data_ok = 1'b0;
                if (!cur.we && ad_oe) rd_float_ok = 1'b0;
            end else begin
                ext_wait = 1'b0;
                ad_i = 16'hBEEF;
            end

            if (!sl && prev_sl) begin
                meas_len = str_len;
                if (!last_we) begin rg_on = 1'b1; rgap = 1; end
                else begin wh_on = 1'b1; whold = 0; hold_wd = cur.wdata; end
            end else if (rg_on) begin
                if (astb && ad_oe) begin last_rgap = rgap; rg_on = 1'b0; end
                else rgap++;
            end
            if (wh_on) begin
                if (ad_oe && ad_o == hold_wd) whold++;
                else begin last_whold = whold; wh_on = 1'b0; end
            end

            if (ready) begin
                if (sb_q.size() == 0) begin
                    chk_eq("R6 ready with no cycle outstanding", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk_eq("R2 address latched by strobe", addr_seen, it.addr);
                    chk_eq("R2 address strobe high ticks", meas_astb, it.exp_astb);
                    chk_eq("R3 strobe delay after address strobe", meas_gap, it.exp_gap);
                    if (it.nwait == 0) chk_eq("R4 strobe low ticks", meas_len, it.exp_len);
                    else               chk_eq("R5 strobe low ticks with wait", meas_len, it.exp_len);
                    if (it.we) begin
                        chk_eq("R7 write data on pins during strobe", data_ok, 1);
                        chk_eq("R7 byte strobes follow enables", wr_seen, it.be);
                    end else begin
                        chk_eq("R6 pins float during read strobe", rd_float_ok, 1);
                        chk_eq("R6 read data captured at strobe rise", rdata, mem_model(it.addr));
                    end
                end
            end
            prev_astb = astb;
            prev_sl   = sl;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk_eq("watchdog expired", 1, 0);
        report();
    end

    initial begin
        int ack_wait, rises;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 astb low", astb, 0);
        chk_eq("R1 rd_n high", rd_n, 1);
        chk_eq("R1 wr_n high", wr_n, 2'b11);
        chk_eq("R1 ad_oe low", ad_oe, 0);
        chk_eq("R1 ctl_oe high", ctl_oe, 1);
        chk_eq("R1 hold_ack low", hold_ack, 0);
        chk_eq("R1 ready low", ready, 0);
        chk_eq("R1 busy low", busy, 0);

        // R4 basic read and write, several wait counts
        issue(1'b0, 16'h1234, 16'h0, 2'b00, 0); drain();
        wait_clks = 2'd1; last_whold = -1;
        issue(1'b1, 16'h0456, 16'hA5C3, 2'b01, 0); drain();
        chk_eq("R7 write data hold ticks", last_whold, 2);
        // R11 slot occupancy after accept
        wait_clks = 2'd0;
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 16'h0100;
        sb_q.push_back('{1'b0, 16'h0100, 16'h0, 2'b00, 2, 1, 2, 0});
        @(negedge clk);
        req = 1'b0;
        chk_eq("R11 busy after accepted request", busy, 1);
        drain();

        // R2 R3 region-1 setup and hold waits, longest programmable wait
        asw_en = 2'b10; ahw_en = 2'b10; wait_clks = 2'd3;
        issue(1'b0, 16'h8421, 16'h0, 2'b00, 0); drain();
        issue(1'b0, 16'h0421, 16'h0, 2'b00, 0); drain();
        asw_en = 2'b01; ahw_en = 2'b00; wait_clks = 2'd0;
        issue(1'b1, 16'h0777, 16'h1F2E, 2'b10, 0); drain();

        // R5 external wait, held high from strobe start
        wait_clks = 2'd2;
        issue(1'b1, 16'h8003, 16'h3C3C, 2'b11, 2); drain();
        wait_clks = 2'd0;
        issue(1'b0, 16'h0ABC, 16'h0, 2'b00, 1); drain();
        wait_clks = 2'd1;
        issue(1'b0, 16'h8ABC, 16'h0, 2'b00, 3); drain();

        // R8 back-to-back reads with and without idle clock
        asw_en = 2'b00; wait_clks = 2'd0; idle_en = 1'b0; last_rgap = -1;
        issue(1'b0, 16'h0010, 16'h0, 2'b00, 0);
        issue(1'b0, 16'h0020, 16'h0, 2'b00, 0);
        drain();
        chk_eq("R8 read-to-address ticks, no idle", last_rgap, 2);
        idle_en = 1'b1; last_rgap = -1;
        issue(1'b0, 16'h0030, 16'h0, 2'b00, 0);
        issue(1'b0, 16'h0040, 16'h0, 2'b00, 0);
        drain();
        chk_eq("R8 read-to-address ticks, one idle", last_rgap, 4);
        idle_en = 1'b0;

        // R9 hold from idle
        hold_req = 1'b1;
        @(negedge clk);
        chk_eq("R9 hold granted from idle", hold_ack, 1);
        chk_eq("R9 controls float during hold", ctl_oe, 0);
        // R10 request queued while held
        rises = astb_rises;
        issue(1'b1, 16'h0900, 16'h6789, 2'b11, 0);
        repeat (6) @(negedge clk);
        chk_eq("R10 no cycle started while held", astb_rises - rises, 0);
        chk_eq("R11 request still pending while held", busy, 1);
        hold_req = 1'b0;
        @(negedge clk);
        chk_eq("R10 hold_ack low after release", hold_ack, 0);
        chk_eq("R10 controls driven after release", ctl_oe, 1);
        drain();

        // R9 hold requested in mid-cycle is deferred
        wait_clks = 2'd3;
        issue(1'b1, 16'h0B00, 16'h4242, 2'b01, 0);
        while (wr_n == 2'b11) @(negedge clk);
        hold_req = 1'b1;
        ack_wait = 0;
        while (!hold_ack && ack_wait < 100) begin
            @(negedge clk);
            ack_wait++;
        end
        chk_eq("R9 hold granted after cycle end", hold_ack, 1);
        chk_eq("R9 cycle completed before grant", sb_q.size(), 0);
        chk_eq("R9 grant deferred past strobe", (ack_wait > 8) ? 1 : 0, 1);
        hold_req = 1'b0;
        repeat (3) @(negedge clk);
        wait_clks = 2'd0;

        report();
    end

endmodule